// File: doc/BRIEF.md
# Bitstream Over-Range Detector

This block watches the one-bit output stream of a sigma-delta modulator on channel 1 and raises an over-range flag when that stream stops toggling. A modulator that holds the same level for many clocks in a row is being driven near or past full scale, and this is true in either polarity. The block counts how long the current run of identical bits has lasted. The flag is high while that run has reached a threshold, set by a parameter that defaults to 25 modulator samples.

Samples are taken only on system clocks where the modulator clock enable is high. The block has no channel-select input, so it keeps monitoring channel 1 whatever channel the rest of the converter is working on. Near full scale, the stream still breaks its runs now and then, so the flag shows up as short, irregular pulses. Past full scale, the stream no longer toggles and the flag stays high.

Top module: `bitstream_ovr_detect`

## Requirements
- R1: While reset (rst_n low at a clock edge) is applied, and after it is released, the run length is zero and ovr_flag is low until a fresh run reaches the threshold.
- R2: When THRESHOLD consecutive enabled samples are all 1, ovr_flag is high in the cycle after the clock edge that takes the THRESHOLD-th sample.
- R3: When THRESHOLD consecutive enabled samples are all 0, ovr_flag is high in the cycle after the clock edge that takes the THRESHOLD-th sample.
- R4: An enabled sample that differs from the previous enabled sample restarts the run at length 1, so ovr_flag is low in the following cycle.
- R5: On cycles where mod_ce is low, mod_bit is ignored and ovr_flag keeps its value.
- R6: A run much longer than THRESHOLD (hundreds of samples) keeps ovr_flag high for its whole length. The counter saturates and never wraps.
- R7: A run of THRESHOLD-1 identical samples that ends in a change never raises ovr_flag.
- R8: A stream whose runs straddle the threshold gives ovr_flag pulses that are high exactly on the samples where the current run length is THRESHOLD or more.
- R9: A reset applied in the middle of a long run clears ovr_flag at once, and the flag is high again only after THRESHOLD new identical samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_ce | input | 1 | Modulator clock enable: one sample is taken per high cycle |
| mod_bit | input | 1 | Modulator data bit for channel 1 |
| ovr_flag | output | 1 | Over-range flag, high while the current run is at least THRESHOLD samples long |

## Verification
Two cases can collide in one cycle. The first is when a run at THRESHOLD-1 samples would have reached the threshold, but the sample that arrives on that edge is a changed bit. The bench provokes this on purpose and expects the flag to stay low and the run to restart at 1. The second collision is a reset that arrives on the same edge as an enabled sample that continues a saturated run. There the reset must win and the flag must drop in the next cycle. The bench's behavioural model judges both cases as it does every other cycle: it holds an integer run length that is updated on each edge, and the model's flag is compared with ovr_flag between edges.

// File: rtl/orl_pkg.sv
// Package: shared types for the bitstream over-range detector.
// Assumes: nothing beyond IEEE 1800-2017.
package orl_pkg;

    // What the run counter should do with the current cycle's sample.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,   // no sample this cycle
        ACT_RESTART = 2'd1,   // new level or first sample: run becomes 1
        ACT_EXTEND  = 2'd2    // same level as before: run grows by one
    } run_act_t;

endpackage

// File: rtl/orl_sample_reg.sv
// Module: orl_sample_reg
// Holds the level of the last enabled modulator sample and classifies
// the present sample as a hold, a restart or an extension of the run.
// Assumes: mod_ce marks valid samples; synchronous active-low reset.
module orl_sample_reg
    import orl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mod_ce,
    input  logic     mod_bit,
    output run_act_t act
);

    logic last_bit_q;
    logic have_last_q;

    // Record the level and the fact that a sample has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bit_q  <= 1'b0;
            have_last_q <= 1'b0;
        end else if (mod_ce) begin
            last_bit_q  <= mod_bit;
            have_last_q <= 1'b1;
        end
    end

    // Classify the incoming sample against the stored level.
    always_comb begin
        if (!mod_ce)
            act = ACT_HOLD;
        else if (have_last_q && (mod_bit == last_bit_q))
            act = ACT_EXTEND;
        else
            act = ACT_RESTART;
    end

    // R5: with no enable, the sample is never taken as part of a run.
    assert_noce_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_ce |-> act == ACT_HOLD);

    // R4: a level that differs from the stored one is never an extension.
    assert_change_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ce && have_last_q && mod_bit != last_bit_q) |-> act == ACT_RESTART);

endmodule

// File: rtl/orl_run_counter.sv
// Module: orl_run_counter
// Counts the length of the current run of identical samples, saturating
// at THRESHOLD so that it never wraps.
// Assumes: THRESHOLD >= 2; act comes from orl_sample_reg.
module orl_run_counter
    import orl_pkg::*;
#(
    parameter int THRESHOLD = 25,
    localparam int CNT_W    = $clog2(THRESHOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  run_act_t         act,
    output logic [CNT_W-1:0] run_len
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] run_q;

    // Advance, restart or hold the run length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else begin
            case (act)
                ACT_RESTART: run_q <= ONE;
                ACT_EXTEND:  run_q <= (run_q == LIMIT) ? LIMIT : run_q + ONE;
                default:     run_q <= run_q;
            endcase
        end
    end

    assign run_len = run_q;

    // R6: the run length never goes past the limit.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT);

    // R5: the count does not move in a cycle without a sample.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_HOLD |=> $stable(run_q));

    // R6: once saturated, a further extension keeps it saturated.
    assert_sat_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == LIMIT && act == ACT_EXTEND) |=> run_q == LIMIT);

endmodule

// File: rtl/orl_flag_gen.sv
// Module: orl_flag_gen
// Drives the over-range flag from the run length: high while the run
// has reached THRESHOLD.
// Assumes: run_len saturates at THRESHOLD.
module orl_flag_gen #(
    parameter int THRESHOLD = 25,
    localparam int CNT_W    = $clog2(THRESHOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] run_len,
    output logic             flag
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);

    // Compare the run length with the threshold.
    always_comb flag = (run_len >= LIMIT);

    // R2: a new flag only rises after the run counted up to the limit.
    assert_rise_from_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(run_len) == LIMIT - CNT_W'(1));

endmodule

// File: rtl/bitstream_ovr_detect.sv
// Module: bitstream_ovr_detect (top)
// Over-range detector for a 1-bit modulator stream on channel 1: flags
// runs of THRESHOLD or more identical enabled samples, of either polarity.
// Assumes: mod_bit is valid on cycles with mod_ce high; THRESHOLD >= 2;
// synchronous active-low reset.
module bitstream_ovr_detect #(
    parameter int THRESHOLD = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_ce,
    input  logic mod_bit,
    output logic ovr_flag
);
    import orl_pkg::*;

    localparam int CNT_W = $clog2(THRESHOLD + 1);

    run_act_t         act;
    logic [CNT_W-1:0] run_len;
    logic             last_seen_q;

    orl_sample_reg u_sample (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_ce  (mod_ce),
        .mod_bit (mod_bit),
        .act     (act)
    );

    orl_run_counter #(.THRESHOLD(THRESHOLD)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .run_len (run_len)
    );

    orl_flag_gen #(.THRESHOLD(THRESHOLD)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_len (run_len),
        .flag    (ovr_flag)
    );

    // Port-level copy of the last sampled level, used only by the checks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_seen_q <= 1'b0;
        else if (mod_ce)
            last_seen_q <= mod_bit;
    end

    // R1: the flag is low in the cycle after a reset edge.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !ovr_flag);

    // R4: a changed enabled sample leaves the flag low next cycle.
    assert_drop_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ce && ovr_flag && mod_bit != last_seen_q) |=> !ovr_flag);

    // R5: without an enable, the flag keeps its value.
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_ce |=> $stable(ovr_flag));

    // R2: a rising flag follows an enabled sample that matched the last one.
    assert_rise_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(mod_ce));

endmodule

// File: tb/tb_bitstream_ovr_detect.sv
// Bench for bitstream_ovr_detect: a behavioural model of the run length
// is compared with ovr_flag on every clock, between edges.
module tb_bitstream_ovr_detect;

    localparam int TH = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_ce = 1'b0;
    logic mod_bit = 1'b0;
    logic ovr_flag;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string tag = "R1";

    int m_len = 0;
    bit m_prev = 1'b0;
    bit m_flag;

    bitstream_ovr_detect #(.THRESHOLD(TH)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_ce   (mod_ce),
        .mod_bit  (mod_bit),
        .ovr_flag (ovr_flag)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Reference model: run length of identical enabled samples.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n)
            m_len = 0;
        else if (mod_ce) begin
            if (m_len != 0 && mod_bit == m_prev)
                m_len = (m_len >= TH) ? TH : m_len + 1;
            else
                m_len = 1;
            m_prev = mod_bit;
        end
    end

    // Compare between edges on every clock.
    always @(negedge clk) begin
        m_flag = (m_len >= TH);
        vectors++;
        if (ovr_flag !== m_flag) begin
            miscompares++;
            $display("FAIL %s: ovr_flag=%b expected %b (run %0d)", tag, ovr_flag, m_flag, m_len);
        end
    end

    // Watchdog.
    initial begin
        wait (cycles > 100000);
        miscompares++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    // n enabled samples of level b; with gaps, idle cycles carry a toggled bit.
    task automatic run(input bit b, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            mod_ce = 1'b1; mod_bit = b; tick();
            if (gaps && (i % 3 == 1)) begin
                mod_ce = 1'b0; mod_bit = ~b; tick(); tick();
            end
        end
        mod_ce = 1'b0;
    endtask

    // Explicit spot check at the port.
    task automatic expect_flag(input bit exp, input string r);
        vectors++;
        if (ovr_flag !== exp) begin
            miscompares++;
            $display("FAIL %s: ovr_flag=%b expected %b", r, ovr_flag, exp);
        end
    endtask

    initial begin
        tag = "R1"; rst_n = 1'b0;
        tick(); tick(); tick();
        expect_flag(1'b0, "R1");
        @(posedge clk); rst_n = 1'b1; tick();
        expect_flag(1'b0, "R1");

        tag = "R7"; run(1'b1, TH - 1, 1'b0); expect_flag(1'b0, "R7");
        run(1'b0, 1, 1'b0);              // change at the would-be threshold
        expect_flag(1'b0, "R7");

        tag = "R3"; run(1'b0, TH - 1, 1'b0); expect_flag(1'b1, "R3");
        tag = "R4"; run(1'b1, 1, 1'b0); expect_flag(1'b0, "R4");
        tag = "R2"; run(1'b1, TH - 1, 1'b1); expect_flag(1'b1, "R2");

        tag = "R5";
        for (int i = 0; i < 20; i++) begin
            mod_ce = 1'b0; mod_bit = i[0]; tick();
        end
        expect_flag(1'b1, "R5");

        tag = "R6"; run(1'b1, 300, 1'b0); expect_flag(1'b1, "R6");
        run(1'b0, 300, 1'b1); expect_flag(1'b1, "R6");

        tag = "R8";
        for (int k = 0; k < 12; k++) begin
            run(k[0], TH - 3 + (k % 5), k[1]);
        end
        run(1'b1, 1, 1'b0);

        tag = "R9"; run(1'b0, TH + 10, 1'b0);
        expect_flag(1'b1, "R9");
        mod_ce = 1'b1; mod_bit = 1'b0; rst_n = 1'b0; tick();
        expect_flag(1'b0, "R9");
        rst_n = 1'b1;
        run(1'b0, TH - 1, 1'b0); expect_flag(1'b0, "R9");
        run(1'b0, 1, 1'b0); expect_flag(1'b1, "R9");

        tick(); tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule